// File: doc/BRIEF.md
# Set-Associative TLB Lookup With Fault Reporting

This block translates a virtual address through a four-way, sixteen-index translation buffer. A lookup compares the page number and the address-space tag of every way at the selected index. The lowest hitting way is then screened by up to four enabled protection checks, which are taken in a fixed order. On success the block returns the physical address and the granted permissions. On failure it returns an exception vector. Unless the lookup was a debug probe, a failure also loads a select register and a cause register, and steps a 16-bit LFSR whose low bits pick the way to refill after a miss.

One parameter chooses between the instruction-fetch flavour (vectors from 4) and the data flavour (vectors from 8); a core uses one of each. Entries are loaded one at a time through a write port that names the way and the index. A lookup accepted in one cycle has its response registered two clock edges later, and a new lookup may start every cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual page is vaddr[31:13] and the index is vaddr[16:13]; all four ways at that index take part in the compare.
- R2: A way hits when its stored page equals the virtual page and either its global flag (lo bit 4) is set or its stored tag (hi[7:0]) equals lk_pid. When several ways hit, the lowest-numbered way wins. Entry hi word: page in [31:13], tag in [7:0]. Entry lo word: frame in [31:13], valid bit 3, kernel bit 2, writable bit 1, executable bit 0.
- R3: A successful lookup sets rsp_hit. It returns rsp_paddr = {frame, vaddr[12:0]} and rsp_perm = {exec, write, read}. Read is always granted and write follows the entry's writable bit. On the instruction side exec is granted when the exec check is enabled or the entry is executable; on the data side exec is never granted. A failed lookup returns zero address and zero permissions.
- R4: The vector base is 4 on the instruction side and 8 on the data side. A miss reports the base. A success reports vector 0.
- R5: The check enables are lk_chk bit 3 (write), bit 2 (kernel), bit 1 (exec) and bit 0 (valid). After a hit the checks are taken in this order: (a) kernel entry with lk_user and kernel check, base+2; (b) data-side store to a non-writable entry with write check, base+3; (c) instruction-side fetch from a non-executable entry with exec check, base+3; (d) entry with its valid bit clear and valid check, base+1.
- R6: The LFSR resets to 0xCCCC. On every non-debug fault it shifts right by one, and its new bit 15 is the parity of (old state AND 0x8805).
- R7: The fault way is the LFSR's bits [1:0] taken before the shift for a miss, and the hitting way for a protection fault.
- R8: On a non-debug fault, tlb_sel becomes {way, index}. mm_cause becomes {vpage in [31:13], zero in [12:10], access code in [9:8], lk_pid in [7:0]}, where the access code is 0 for fetch, 1 for load and 2 for store. Neither register changes at any other time.
- R9: A lookup with lk_debug set reports its result normally but leaves tlb_sel, mm_cause and the LFSR unchanged.
- R10: A lookup presented with lk_valid in the cycle before clock edge N has its response on the outputs with rsp_valid from edge N+1 to edge N+2; lookups may be issued every cycle.
- R11: A write takes effect at the clock edge that samples wr_en. A lookup presented in the same cycle as a write to the same slot sees the old entry, and the next lookup sees the new one.
- R12: Synchronous reset clears rsp_valid, tlb_sel and mm_cause and reloads the LFSR seed; entry contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Index to write |
| wr_hi | input | 32 | Entry hi word (page, tag) |
| wr_lo | input | 32 | Entry lo word (frame, flags) |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_pid | input | 8 | Current address-space tag |
| lk_user | input | 1 | Access is from user mode |
| lk_store | input | 1 | Data-side access is a store |
| lk_debug | input | 1 | Probe without side effects |
| lk_chk | input | 4 | Check enables {write, kernel, exec, valid} |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted {exec, write, read} |
| rsp_vec | output | 4 | Exception vector on failure |
| tlb_sel | output | 6 | Fault way and index |
| mm_cause | output | 32 | Fault cause word |

## Verification
Two things can happen in the same cycle. An entry write can land on the slot that a lookup is reading, and a fault response can leave while the next lookup is already in its compare stage and about to use the freshly stepped LFSR. The bench provokes the first with directed writes timed into the same cycle as a lookup to the rewritten slot, and with random write traffic during back-to-back lookups. It provokes the second with runs of consecutive misses. A behavioural model judges every cycle of both flavours. The model snapshots entries before applying writes and steps its own LFSR, and it checks the old-entry outcome and each victim way in turn.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hCCCC;
  localparam logic [15:0] LFSR_TAPS = 16'h8805;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_code_e;

  // Flag positions inside the stored 5-bit flag field
  localparam int FLG_X = 0;
  localparam int FLG_W = 1;
  localparam int FLG_K = 2;
  localparam int FLG_V = 3;
  localparam int FLG_G = 4;

  // Check-enable positions
  localparam int CHK_V = 0;
  localparam int CHK_X = 1;
  localparam int CHK_K = 2;
  localparam int CHK_W = 3;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {^(s & LFSR_TAPS), s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/tlb_way_ram.sv
module tlb_way_ram #(
  parameter int IDX_W = 4,
  parameter int DW    = 51
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  // Read-first: a same-cycle write is seen by the following read only
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlb_hit_sel.sv
module tlb_hit_sel #(
  parameter int WAYS  = 4,
  parameter int VPN_W = 19,
  parameter int PID_W = 8,
  parameter int ENT_W = 2*VPN_W + PID_W + 5,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][ENT_W-1:0] ents,
  input  logic [VPN_W-1:0]           vpage,
  input  logic [PID_W-1:0]           pid,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [VPN_W-1:0]           hit_pfn,
  output logic [3:0]                 hit_flg
);
  import tlb_pkg::*;

  logic [WAYS-1:0]            match;
  logic [WAYS-1:0][VPN_W-1:0] pfn;
  logic [WAYS-1:0][3:0]       flg;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic [VPN_W-1:0] e_vpn;
    logic [PID_W-1:0] e_pid;
    logic             e_glb;
    assign e_vpn    = ents[w][ENT_W-1 -: VPN_W];
    assign e_pid    = ents[w][ENT_W-VPN_W-1 -: PID_W];
    assign pfn[w]   = ents[w][5 +: VPN_W];
    assign e_glb    = ents[w][FLG_G];
    assign flg[w]   = ents[w][3:0];
    assign match[w] = (e_vpn == vpage) && (e_glb || (e_pid == pid));
  end

  // Walk from the top way down so the lowest match is left standing
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    hit_pfn = '0;
    hit_flg = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
        hit_pfn = pfn[w];
        hit_flg = flg[w];
      end
    end
  end
endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk #(
  parameter int INST_SIDE = 0
) (
  input  logic [3:0] flg,
  input  logic [3:0] chk,
  input  logic       user,
  input  logic       store,
  output logic       fault,
  output logic [1:0] vec_off,
  output logic [2:0] perm
);
  import tlb_pkg::*;

  logic kern_f, wr_f, ex_f, inv_f;
  logic unused_sink;

  assign kern_f = chk[CHK_K] && flg[FLG_K] && user;
  assign inv_f  = chk[CHK_V] && !flg[FLG_V];

  if (INST_SIDE != 0) begin : g_inst
    assign wr_f = 1'b0;
    assign ex_f = chk[CHK_X] && !flg[FLG_X];
    assign perm = {chk[CHK_X] || flg[FLG_X], flg[FLG_W], 1'b1};
  end else begin : g_data
    assign wr_f = store && chk[CHK_W] && !flg[FLG_W];
    assign ex_f = 1'b0;
    assign perm = {1'b0, flg[FLG_W], 1'b1};
  end

  assign unused_sink = ^{chk, flg, store};

  always_comb begin
    fault   = 1'b1;
    vec_off = 2'd0;
    if (kern_f)            vec_off = 2'd2;
    else if (wr_f || ex_f) vec_off = 2'd3;
    else if (inv_f)        vec_off = 2'd1;
    else                   fault   = 1'b0;
  end
endmodule

// File: rtl/tlb_fault_state.sv
module tlb_fault_state #(
  parameter int WAY_W     = 2,
  parameter int IDX_W     = 4,
  parameter int VPN_W     = 19,
  parameter int PID_W     = 8,
  parameter int PAGE_BITS = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       upd,
  input  logic                       miss,
  input  logic [WAY_W-1:0]           hit_way,
  input  logic [VPN_W-1:0]           vpage,
  input  logic [PID_W-1:0]           pid,
  input  tlb_pkg::acc_code_e         code,
  output logic [tlb_pkg::LFSR_W-1:0] lfsr_q,
  output logic [WAY_W+IDX_W-1:0]     sel_q,
  output logic [VPN_W+PAGE_BITS-1:0] cause_q
);
  import tlb_pkg::*;

  localparam int PAD_W = PAGE_BITS - PID_W - 2;

  logic [WAY_W-1:0] way;
  assign way = miss ? lfsr_q[WAY_W-1:0] : hit_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q  <= LFSR_SEED;
      sel_q   <= '0;
      cause_q <= '0;
    end else if (upd) begin
      lfsr_q  <= lfsr_step(lfsr_q);
      sel_q   <= {way, vpage[IDX_W-1:0]};
      cause_q <= {vpage, {PAD_W{1'b0}}, code, pid};
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 4,
  parameter int WAYS      = 4,
  parameter int PID_W     = 8,
  parameter int INST_SIDE = 0,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int SEL_W    = WAY_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VA_W-1:0]  wr_hi,
  input  logic [VA_W-1:0]  wr_lo,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_user,
  input  logic             lk_store,
  input  logic             lk_debug,
  input  logic [3:0]       lk_chk,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_perm,
  output logic [3:0]       rsp_vec,
  output logic [SEL_W-1:0] tlb_sel,
  output logic [VA_W-1:0]  mm_cause
);
  import tlb_pkg::*;

  localparam int          VPN_W    = VA_W - PAGE_BITS;
  localparam int          ENT_W    = 2*VPN_W + PID_W + 5;
  localparam logic [3:0]  VEC_BASE = (INST_SIDE != 0) ? 4'd4 : 4'd8;

  // Compact stored entry: {page, tag, frame, g, v, k, w, x}
  logic [ENT_W-1:0] wr_ent;
  logic             unused_bits;
  assign wr_ent = {wr_hi[VA_W-1:PAGE_BITS], wr_hi[PID_W-1:0],
                   wr_lo[VA_W-1:PAGE_BITS], wr_lo[4:0]};
  assign unused_bits = ^{wr_hi[PAGE_BITS-1:PID_W], wr_lo[PAGE_BITS-1:5]};

  logic [WAYS-1:0][ENT_W-1:0] rd_ent;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlb_way_ram #(.IDX_W(IDX_W), .DW(ENT_W)) u_ram (
      .clk   (clk),
      .we    (wr_en && (wr_way == WAY_W'(g))),
      .waddr (wr_idx),
      .wdata (wr_ent),
      .raddr (lk_vaddr[PAGE_BITS +: IDX_W]),
      .rdata (rd_ent[g])
    );
  end

  // Stage 1: request fields aligned with the RAM read
  logic             s1_valid, s1_user, s1_store, s1_dbg;
  logic [VA_W-1:0]  s1_vaddr;
  logic [PID_W-1:0] s1_pid;
  logic [3:0]       s1_chk;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= lk_valid;
    s1_vaddr <= lk_vaddr;
    s1_pid   <= lk_pid;
    s1_user  <= lk_user;
    s1_store <= lk_store;
    s1_dbg   <= lk_debug;
    s1_chk   <= lk_chk;
  end

  logic [VPN_W-1:0] s1_vpage;
  assign s1_vpage = s1_vaddr[VA_W-1:PAGE_BITS];

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [VPN_W-1:0] hit_pfn;
  logic [3:0]       hit_flg;

  tlb_hit_sel #(.WAYS(WAYS), .VPN_W(VPN_W), .PID_W(PID_W), .ENT_W(ENT_W)) u_hit (
    .ents    (rd_ent),
    .vpage   (s1_vpage),
    .pid     (s1_pid),
    .hit     (hit),
    .hit_way (hit_way),
    .hit_pfn (hit_pfn),
    .hit_flg (hit_flg)
  );

  logic       prot_f;
  logic [1:0] prot_off;
  logic [2:0] perm;

  tlb_prot_chk #(.INST_SIDE(INST_SIDE)) u_prot (
    .flg     (hit_flg),
    .chk     (s1_chk),
    .user    (s1_user),
    .store   (s1_store),
    .fault   (prot_f),
    .vec_off (prot_off),
    .perm    (perm)
  );

  logic      ok;
  acc_code_e code;
  assign ok   = hit && !prot_f;
  assign code = (INST_SIDE != 0) ? ACC_FETCH : (s1_store ? ACC_STORE : ACC_LOAD);

  // Stage 2: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_vec   <= '0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_hit   <= s1_valid && ok;
      rsp_paddr <= ok ? {hit_pfn, s1_vaddr[PAGE_BITS-1:0]} : '0;
      rsp_perm  <= ok ? perm : 3'b000;
      rsp_vec   <= ok ? 4'd0 : (VEC_BASE + (hit ? {2'b00, prot_off} : 4'd0));
    end
  end

  logic [LFSR_W-1:0] lfsr_q;

  tlb_fault_state #(
    .WAY_W(WAY_W), .IDX_W(IDX_W), .VPN_W(VPN_W), .PID_W(PID_W), .PAGE_BITS(PAGE_BITS)
  ) u_fault (
    .clk     (clk),
    .rst     (rst),
    .upd     (s1_valid && !ok && !s1_dbg),
    .miss    (!hit),
    .hit_way (hit_way),
    .vpage   (s1_vpage),
    .pid     (s1_pid),
    .code    (code),
    .lfsr_q  (lfsr_q),
    .sel_q   (tlb_sel),
    .cause_q (mm_cause)
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        lk_valid,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [2:0]  rsp_perm,
  input logic [3:0]  rsp_vec,
  input logic [5:0]  tlb_sel,
  input logic [31:0] mm_cause,
  input logic [15:0] lfsr
);
  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid, 2));

  assert_read_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> rsp_perm[0]);

  assert_vec_base_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_vec[3:2] == 2'b01 || rsp_vec[3:2] == 2'b10));

  assert_hit_novec_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_vec == 4'd0));

  assert_lfsr_on_fault_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(lfsr) |-> (rsp_valid && !rsp_hit));

  assert_sel_on_fault_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(tlb_sel) |-> (rsp_valid && !rsp_hit));

  assert_cause_pad_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mm_cause) |-> (rsp_valid && !rsp_hit && mm_cause[12:10] == 3'b000));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_perm  (rsp_perm),
  .rsp_vec   (rsp_vec),
  .tlb_sel   (tlb_sel),
  .mm_cause  (mm_cause),
  .lfsr      (lfsr_q)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_user = 1'b0, lk_store = 1'b0, lk_debug = 1'b0;
  logic [3:0]  lk_chk = '0;

  logic        d_valid [2];
  logic        d_hit   [2];
  logic [31:0] d_paddr [2];
  logic [2:0]  d_perm  [2];
  logic [3:0]  d_vec   [2];
  logic [5:0]  d_sel   [2];
  logic [31:0] d_cause [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  // side 0: data flavour, side 1: instruction flavour
  tlb_xlate #(.INST_SIDE(0)) i_tlb_xlate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_pid(lk_pid), .lk_user(lk_user), .lk_store(lk_store), .lk_debug(lk_debug),
    .lk_chk(lk_chk), .rsp_valid(d_valid[0]), .rsp_hit(d_hit[0]),
    .rsp_paddr(d_paddr[0]), .rsp_perm(d_perm[0]), .rsp_vec(d_vec[0]),
    .tlb_sel(d_sel[0]), .mm_cause(d_cause[0]));

  tlb_xlate #(.INST_SIDE(1)) i_tlb_xlate_ifetch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_pid(lk_pid), .lk_user(lk_user), .lk_store(lk_store), .lk_debug(lk_debug),
    .lk_chk(lk_chk), .rsp_valid(d_valid[1]), .rsp_hit(d_hit[1]),
    .rsp_paddr(d_paddr[1]), .rsp_perm(d_perm[1]), .rsp_vec(d_vec[1]),
    .tlb_sel(d_sel[1]), .mm_cause(d_cause[1]));

  // ---------------- reference model ----------------
  typedef struct {
    bit          valid;
    logic [31:0] vaddr;
    logic [7:0]  pid;
    bit          user, store, dbg;
    logic [3:0]  chk;
    logic [31:0] hi [4];
    logic [31:0] lo [4];
  } req_t;

  logic [31:0] m_hi [4][16];
  logic [31:0] m_lo [4][16];
  req_t        pipe [$];

  logic [15:0] m_lfsr  [2];
  logic [5:0]  m_sel   [2];
  logic [31:0] m_cause [2];
  bit          e_valid [2];
  bit          e_hit   [2];
  logic [31:0] e_paddr [2];
  logic [2:0]  e_perm  [2];
  logic [3:0]  e_vec   [2];

  int n_cmp  = 0;
  int n_fail = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  task automatic model_eval(input int s, input req_t r);
    int         hw;
    logic [18:0] vp;
    logic [31:0] lo;
    logic [1:0]  way;
    logic [1:0]  code;
    int          base;
    int          vec;
    vp = r.vaddr[31:13];
    hw = -1;
    for (int w = 0; w < 4; w++)
      if (hw < 0 && r.hi[w][31:13] == vp && (r.lo[w][4] || r.hi[w][7:0] == r.pid)) hw = w;
    base = (s == 1) ? 4 : 8;
    code = (s == 1) ? 2'd0 : (r.store ? 2'd2 : 2'd1);
    vec  = -1;
    lo   = '0;
    if (hw < 0) begin
      vec = base;
      way = m_lfsr[s][1:0];
    end else begin
      lo  = r.lo[hw];
      way = 2'(hw);
      if (r.chk[2] && lo[2] && r.user)                      vec = base + 2;
      else if (s == 0 && r.store && r.chk[3] && !lo[1])     vec = base + 3;
      else if (s == 1 && r.chk[1] && !lo[0])                vec = base + 3;
      else if (r.chk[0] && !lo[3])                          vec = base + 1;
    end
    if (vec < 0) begin
      e_hit[s]   = 1'b1;
      e_paddr[s] = {lo[31:13], r.vaddr[12:0]};
      e_perm[s]  = {(s == 1) && (r.chk[1] || lo[0]), lo[1], 1'b1};
      e_vec[s]   = 4'd0;
    end else begin
      e_hit[s]   = 1'b0;
      e_paddr[s] = '0;
      e_perm[s]  = '0;
      e_vec[s]   = 4'(vec);
      if (!r.dbg) begin
        m_sel[s]   = {way, vp[3:0]};
        m_cause[s] = {vp, 3'b000, code, r.pid};
        m_lfsr[s]  = {^(m_lfsr[s] & 16'h8805), m_lfsr[s][15:1]};
      end
    end
  endtask

  always @(posedge clk) begin
    req_t nr;
    started = 1'b1;
    if (rst) begin
      pipe.delete();
      for (int s = 0; s < 2; s++) begin
        m_lfsr[s] = 16'hCCCC; m_sel[s] = '0; m_cause[s] = '0;
        e_valid[s] = 1'b0; e_hit[s] = 1'b0; e_paddr[s] = '0; e_perm[s] = '0; e_vec[s] = '0;
      end
    end else begin
      if (pipe.size() > 0) begin
        req_t r;
        r = pipe.pop_front();
        for (int s = 0; s < 2; s++) begin
          e_valid[s] = r.valid;
          if (r.valid) model_eval(s, r);
          else begin
            e_hit[s] = 1'b0; e_paddr[s] = '0; e_perm[s] = '0;
          end
        end
      end else begin
        for (int s = 0; s < 2; s++) begin
          e_valid[s] = 1'b0; e_hit[s] = 1'b0;
        end
      end
      nr.valid = lk_valid; nr.vaddr = lk_vaddr; nr.pid = lk_pid;
      nr.user = lk_user; nr.store = lk_store; nr.dbg = lk_debug; nr.chk = lk_chk;
      for (int w = 0; w < 4; w++) begin
        nr.hi[w] = m_hi[w][lk_vaddr[16:13]];
        nr.lo[w] = m_lo[w][lk_vaddr[16:13]];
      end
      pipe.push_back(nr);
    end
    if (wr_en) begin
      m_hi[wr_way][wr_idx] = wr_hi;
      m_lo[wr_way][wr_idx] = wr_lo;
    end
  end

  task automatic chk32(input string tag, input string side, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, side, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int s = 0; s < 2; s++) begin
        string sn;
        sn = (s == 1) ? "ifetch" : "data";
        chk32("R10 R12 rsp_valid", sn, 32'(d_valid[s]), 32'(e_valid[s]));
        if (e_valid[s]) begin
          chk32("R1 R2 R11 rsp_hit", sn, 32'(d_hit[s]), 32'(e_hit[s]));
          chk32("R3 R11 rsp_paddr", sn, d_paddr[s], e_paddr[s]);
          chk32("R3 rsp_perm", sn, 32'(d_perm[s]), 32'(e_perm[s]));
          if (!e_hit[s]) chk32("R4 R5 rsp_vec", sn, 32'(d_vec[s]), 32'(e_vec[s]));
        end
        chk32("R6 R7 R8 R9 R12 tlb_sel", sn, 32'(d_sel[s]), 32'(m_sel[s]));
        chk32("R8 R9 R12 mm_cause", sn, d_cause[s], m_cause[s]);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mk_hi(input int vpn, input int pid);
    return {19'(vpn), 5'b0, 8'(pid)};
  endfunction

  function automatic logic [31:0] mk_lo(input int pfn, input logic [4:0] flg);
    return {19'(pfn), 8'b0, flg};
  endfunction

  task automatic put(input int w, input int i, input logic [31:0] hi, input logic [31:0] lo);
    wr_en = 1'b1; wr_way = 2'(w); wr_idx = 4'(i); wr_hi = hi; wr_lo = lo;
  endtask

  task automatic ask(input int vpn, input int pid, input bit user, input bit store,
                     input bit dbg, input logic [3:0] chk);
    lk_valid = 1'b1; lk_vaddr = {19'(vpn), 13'h0A5C}; lk_pid = 8'(pid);
    lk_user = user; lk_store = store; lk_debug = dbg; lk_chk = chk;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic print_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // Fill every slot: page = (way+1)*16+idx, tag 0x10+way, flags from index, way 3 global
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 16; i++) begin
        put(w, i, mk_hi((w+1)*16 + i, 16'h10 + w), mk_lo(16'h400 + w*16 + i, {w == 3, 4'(i)}));
        @(negedge clk);
      end
    wr_en = 1'b0;
    // R2 plain hit (way 1, idx 15: all flags set), matching tag
    ask(2*16 + 15, 8'h11, 0, 1, 0, 4'hF); idle_cycle();
    // R4 miss on both sides, then back-to-back misses stepping the LFSR (R6 R7)
    for (int k = 0; k < 5; k++) begin
      ask(7*16 + k, 8'h11, 0, 0, 0, 4'h0); @(negedge clk);
    end
    idle_cycle();
    // R2 tag mismatch on non-global way gives a miss; global way 3 hits with any tag
    ask(2*16 + 15, 8'h77, 0, 0, 0, 4'h0); @(negedge clk);
    ask(4*16 + 15, 8'h77, 0, 0, 0, 4'hF); idle_cycle();
    // R2 lowest way wins: copy page of way 1 into way 2 at idx 6 with another frame
    put(2, 6, mk_hi(2*16 + 6, 8'h11), mk_lo(20'h7AAA, 5'b01111)); idle_cycle();
    ask(2*16 + 6, 8'h11, 0, 0, 0, 4'h0); idle_cycle();
    // R5 priority: idx 4 has kernel only (v=0,w=0,x=0)
    ask(1*16 + 4, 8'h10, 1, 1, 0, 4'hF); @(negedge clk);   // kernel first
    ask(1*16 + 4, 8'h10, 0, 1, 0, 4'hF); @(negedge clk);   // write / exec
    ask(1*16 + 4, 8'h10, 0, 0, 0, 4'hF); @(negedge clk);   // load: data valid, ifetch exec
    ask(1*16 + 4, 8'h10, 0, 0, 0, 4'h1); @(negedge clk);   // valid only
    ask(1*16 + 4, 8'h10, 1, 1, 0, 4'h0); idle_cycle();     // no checks: success
    // R9 debug miss and debug protection fault leave state alone
    ask(9*16 + 2, 8'h10, 0, 0, 1, 4'h0); @(negedge clk);
    ask(1*16 + 4, 8'h10, 1, 0, 1, 4'hF); idle_cycle();
    // R11 write and lookup to the same slot in one cycle, then again
    put(0, 3, mk_hi(6*16 + 3, 8'h10), mk_lo(20'h5555, 5'b01111));
    ask(1*16 + 3, 8'h10, 0, 0, 0, 4'h0); @(negedge clk);
    wr_en = 1'b0;
    ask(1*16 + 3, 8'h10, 0, 0, 0, 4'h0); @(negedge clk);
    ask(6*16 + 3, 8'h10, 0, 0, 0, 4'h0); idle_cycle();
    repeat (3) @(negedge clk);
    // Random traffic with overlapping writes
    for (int n = 0; n < 6000; n++) begin
      int vpn;
      vpn = int'($urandom_range(0, 6)) * 16 + int'($urandom_range(0, 15));
      lk_valid = ($urandom_range(0, 3) != 0);
      lk_vaddr = {19'(vpn), 13'($urandom())};
      lk_pid   = ($urandom_range(0, 4) == 0) ? 8'h55 : 8'(8'h10 + $urandom_range(0, 3));
      lk_user  = 1'($urandom()); lk_store = 1'($urandom());
      lk_debug = ($urandom_range(0, 7) == 0);
      lk_chk   = 4'($urandom());
      wr_en    = ($urandom_range(0, 5) == 0);
      wr_way   = 2'($urandom()); wr_idx = 4'($urandom());
      wr_hi    = mk_hi(int'($urandom_range(1, 5)) * 16 + int'(wr_idx),
                       int'(8'h10) + int'($urandom_range(0, 3)));
      wr_lo    = mk_lo(int'($urandom_range(0, 20'h7FFFF)), 5'($urandom()));
      @(negedge clk);
    end
    idle_cycle();
    repeat (4) @(negedge clk);
    // Reset again mid-run: state returns to reset values (R12)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      print_summary();
      $finish;
    end
  end
endmodule